// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives characters on a single asynchronous serial line. A programmable divider turns the system clock into a sampling tick. Sixteen ticks make one bit period, so one bit lasts 16 × (n+1) clocks, where n is the divider setting. When reception is enabled, a falling edge on the line starts a character. The start bit is confirmed at its middle. Each following data, parity and stop bit is sampled once at its middle, with the least significant data bit first.

When the last stop bit has been sampled, the character moves into a one-entry receive buffer and a one-cycle receive request is raised. Three error flags report an overrun, a framing error and a parity error, and a fourth flag is the OR of those three. Reading the buffer with a strobe releases it and clears the flags. An active-low ready-to-send output tells the far end whether the buffer can accept another character.

The format is chosen with static inputs: 7, 8 or 9 data bits; no, odd or even parity; and one or two stop bits. These inputs are expected to change only while the line is idle.

Top module: `uart_rx_errflags`

## Requirements
- R1: No character is received while `rx_en` is 0. A character starts only with `rx_en` at 1 and a high-to-low transition on `rxd`.
- R2: When a character completes and the buffer is empty, `rx_data` takes the character, `rx_full` becomes 1, and `rx_irq` pulses high for exactly one clock.
- R3: When a character completes while `rx_full` is 1, `rx_data` is overwritten by the new character, `ovr_err` becomes 1, and `rx_irq` stays low.
- R4: `frm_err` becomes 1 when any of the configured stop bits (one if `two_stop`=0, two if `two_stop`=1) is sampled low.
- R5: `parity_mode` encodes 2'b01 = odd, 2'b10 = even, and 2'b00 or 2'b11 = no parity bit. With parity on, `par_err` becomes 1 when the count of ones over the data bits and the parity bit is odd under even parity, or even under odd parity.
- R6: `err_sum` is 1 whenever any of `ovr_err`, `frm_err` or `par_err` is 1.
- R7: If `rxd` is high at the middle of the start bit, the edge is treated as a glitch: nothing is received and the receiver waits for the next falling edge.
- R8: `data_len` encodes 2'd0 = 7 bits, 2'd1 = 8 bits, and 2'd2 or 2'd3 = 9 bits. Data bits arrive least significant first and are placed right-justified in `rx_data`, with the unused upper bits at 0.
- R9: One bit period lasts 16 × (`baud_div`+1) clocks, and each bit is sampled at its 8th tick.
- R10: `rts_n` is 0 only when `rts_func_en`, `rx_en` and the buffer-empty condition all hold; otherwise it is 1.
- R11: A `rd_strobe` pulse clears `rx_full` and all error flags. Driving `rx_en` to 0 clears the error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| rts_func_en | input | 1 | Enables the ready-to-send output |
| baud_div | input | 8 | Divider setting n; tick every n+1 clocks |
| data_len | input | 2 | Character length code |
| parity_mode | input | 2 | Parity selection code |
| two_stop | input | 1 | 1 selects two stop bits |
| rxd | input | 1 | Serial line, idle high |
| rd_strobe | input | 1 | One-clock read of the receive buffer |
| rx_data | output | 9 | Receive buffer contents |
| rx_full | output | 1 | Receive buffer holds unread data |
| rx_irq | output | 1 | One-clock receive request |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing flag |
| par_err | output | 1 | Parity flag |
| err_sum | output | 1 | OR of the three error flags |
| rts_n | output | 1 | Active-low ready to send |

## Verification
The assertions assume that the format inputs and `baud_div` stay constant while a character is in flight, and that `rd_strobe` is a single-clock pulse. Under these assumptions a receive request can only follow a completed character and can never come two clocks in a row. The bench drives the configuration only between frames, holds every line level for whole bit periods, and issues reads only while the line is idle. Glitches are short low pulses that end well before the middle of a start bit.

// File: rtl/uart_rx_pkg.sv
// Package: shared types and encodings for the serial receiver.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package uart_rx_pkg;

    localparam int DATA_W   = 9;   // widest character
    localparam int DIV_W    = 8;   // divider setting width
    localparam int TICKS    = 16;  // ticks per bit
    localparam int SUB_W    = $clog2(TICKS);
    localparam int MID_TICK = TICKS / 2 - 1;
    localparam int CNT_W    = $clog2(DATA_W + 1);

    localparam logic [1:0] PAR_ODD  = 2'b01;
    localparam logic [1:0] PAR_EVEN = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_t;

endpackage

// File: rtl/uart_rx_baud.sv
// Module: tick generator. Emits one tick every div+1 clocks.
// Assumes: restart re-phases the count so a tick follows div+1 clocks later.
module uart_rx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Purpose: count clocks, wrapping at the divider setting.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || cnt == div) cnt <= '0;
        else                                 cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == div) && !restart;
endmodule

// File: rtl/uart_rx_shift.sv
// Module: frame sequencer and shift register.
// It synchronises the line, confirms the start bit, samples each bit
// at its middle tick, and emits a one-clock done pulse carrying the
// character and its framing and parity results.
// Assumes: format inputs are static while a frame is in flight.
module uart_rx_shift
    import uart_rx_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          rxd,
    input  logic          tick,
    input  logic [1:0]    data_len,
    input  logic [1:0]    parity_mode,
    input  logic          two_stop,
    output logic          restart,
    output logic          done,
    output logic [DW-1:0] char_out,
    output logic          frm_out,
    output logic          par_out
);
    logic            s1, s2, prev;
    rx_state_t       state;
    logic [SUB_W-1:0] sub;
    logic [CNT_W-1:0] bitcnt;
    logic [DW-1:0]   sh;
    logic            ones_odd, ferr;
    logic            mid, last, par_en, odd_sel;
    logic [CNT_W-1:0] nbits;
    logic [DW-1:0]   justified;

    assign mid     = tick && (sub == SUB_W'(MID_TICK));
    assign last    = tick && (sub == SUB_W'(TICKS - 1));
    assign par_en  = (parity_mode == PAR_ODD) || (parity_mode == PAR_EVEN);
    assign odd_sel = (parity_mode == PAR_ODD);
    assign restart = (state == ST_IDLE) && rx_en && prev && !s2;

    // Purpose: map the length code to a bit count and right-justify.
    always_comb begin
        case (data_len)
            2'd0:    begin nbits = CNT_W'(DW - 2); justified = sh >> 2; end
            2'd1:    begin nbits = CNT_W'(DW - 1); justified = sh >> 1; end
            default: begin nbits = CNT_W'(DW);     justified = sh;      end
        endcase
    end

    // Purpose: two-stage synchroniser plus edge history for the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
        end else begin
            s1 <= rxd; s2 <= s1; prev <= s2;
        end
    end

    // Purpose: step through the frame and assemble the character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; sub <= '0; bitcnt <= '0; sh <= '0;
            ones_odd <= 1'b0; ferr <= 1'b0;
            done <= 1'b0; char_out <= '0; frm_out <= 1'b0; par_out <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state != ST_IDLE && tick) sub <= sub + 1'b1;
            if (!rx_en) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: if (restart) begin
                        state <= ST_START; sub <= '0;
                        ones_odd <= 1'b0; ferr <= 1'b0; bitcnt <= '0;
                    end
                    ST_START: begin
                        if (mid && s2)  state <= ST_IDLE;
                        else if (last)  state <= ST_DATA;
                    end
                    ST_DATA: begin
                        if (mid) begin
                            sh       <= {s2, sh[DW-1:1]};
                            ones_odd <= ones_odd ^ s2;
                        end
                        if (last) begin
                            if (bitcnt == nbits - 1'b1)
                                state <= par_en ? ST_PAR : ST_STOP1;
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (mid)  ones_odd <= ones_odd ^ s2;
                        if (last) state <= ST_STOP1;
                    end
                    ST_STOP1: begin
                        if (mid) begin
                            ferr <= ferr | !s2;
                            if (!two_stop) begin
                                state    <= ST_IDLE;
                                done     <= 1'b1;
                                char_out <= justified;
                                frm_out  <= ferr | !s2;
                                par_out  <= par_en && (ones_odd != odd_sel);
                            end
                        end
                        if (last && two_stop) state <= ST_STOP2;
                    end
                    ST_STOP2: if (mid) begin
                        state    <= ST_IDLE;
                        done     <= 1'b1;
                        char_out <= justified;
                        frm_out  <= ferr | !s2;
                        par_out  <= par_en && (ones_odd != odd_sel);
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_buf.sv
// Module: one-entry receive buffer with error flags and request pulse.
// A read in the same clock as a completion releases the buffer first.
// Assumes: done is a one-clock pulse from the sequencer.
module uart_rx_buf #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          done,
    input  logic [DW-1:0] char_in,
    input  logic          frm_in,
    input  logic          par_in,
    input  logic          rd_strobe,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          rx_irq,
    output logic          ovr_err,
    output logic          frm_err,
    output logic          par_err
);
    logic full_eff;
    logic ovr_base, frm_base, par_base;

    assign full_eff = rx_full && !rd_strobe;
    assign ovr_base = ovr_err && !rd_strobe;
    assign frm_base = frm_err && !rd_strobe;
    assign par_base = par_err && !rd_strobe;

    // Purpose: load the buffer, raise the request, and track the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0; rx_full <= 1'b0; rx_irq <= 1'b0;
            ovr_err <= 1'b0; frm_err <= 1'b0; par_err <= 1'b0;
        end else begin
            rx_irq <= 1'b0;
            if (done) begin
                rx_data <= char_in;
                rx_full <= 1'b1;
                rx_irq  <= !full_eff;
                ovr_err <= ovr_base | full_eff;
                frm_err <= frm_base | frm_in;
                par_err <= par_base | par_in;
            end else begin
                rx_full <= full_eff;
                ovr_err <= ovr_base && rx_en;
                frm_err <= frm_base && rx_en;
                par_err <= par_base && rx_en;
            end
        end
    end
endmodule

// File: rtl/uart_rx_errflags.sv
// Module: top of the serial receiver with error flags.
// Wires the tick generator, the frame sequencer and the buffer, and
// forms the summary error flag and the ready-to-send output.
// Assumes: configuration changes only while the line is idle.
module uart_rx_errflags
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rts_func_en,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [1:0]        data_len,
    input  logic [1:0]        parity_mode,
    input  logic              two_stop,
    input  logic              rxd,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_irq,
    output logic              ovr_err,
    output logic              frm_err,
    output logic              par_err,
    output logic              err_sum,
    output logic              rts_n
);
    logic              tick, restart, done, frm_c, par_c;
    logic [DATA_W-1:0] char_c;

    uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(baud_div),
        .restart(restart), .tick(tick)
    );

    uart_rx_shift #(.DW(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxd(rxd), .tick(tick),
        .data_len(data_len), .parity_mode(parity_mode), .two_stop(two_stop),
        .restart(restart), .done(done), .char_out(char_c),
        .frm_out(frm_c), .par_out(par_c)
    );

    uart_rx_buf #(.DW(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .done(done),
        .char_in(char_c), .frm_in(frm_c), .par_in(par_c),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_full(rx_full),
        .rx_irq(rx_irq), .ovr_err(ovr_err), .frm_err(frm_err),
        .par_err(par_err)
    );

    assign err_sum = ovr_err | frm_err | par_err;
    assign rts_n   = !(rts_func_en && rx_en && !rx_full);
endmodule

// File: rtl/uart_rx_errflags_chk.sv
// Module: property checker bound to the receiver top.
// Assumes: rd_strobe pulses last one clock.
module uart_rx_errflags_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic rx_full,
    input logic rx_irq,
    input logic ovr_err,
    input logic frm_err,
    input logic par_err,
    input logic err_sum,
    input logic rts_n
);
    a_r2_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);
    a_r2_irq_with_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full);
    a_r3_no_irq_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_err) |-> !rx_irq);
    a_r6_sum_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err || frm_err || par_err) |-> err_sum);
    a_r1_no_irq_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_irq);
    a_r11_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !err_sum);
    a_r10_rts_high_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> rts_n);
endmodule

bind uart_rx_errflags uart_rx_errflags_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_full(rx_full),
    .rx_irq(rx_irq), .ovr_err(ovr_err), .frm_err(frm_err),
    .par_err(par_err), .err_sum(err_sum), .rts_n(rts_n)
);

// File: tb/tb_uart_rx_errflags.sv
// Bench: directed scenarios for the serial receiver, one task each.
module tb_uart_rx_errflags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       rts_func_en = 1'b1;
    logic [7:0] baud_div = 8'd1;
    logic [1:0] data_len = 2'd1;
    logic [1:0] parity_mode = 2'b00;
    logic       two_stop = 1'b0;
    logic       rxd = 1'b1;
    logic       rd_strobe = 1'b0;
    logic [8:0] rx_data;
    logic       rx_full, rx_irq, ovr_err, frm_err, par_err, err_sum, rts_n;

    int checks = 0;
    int fails = 0;
    int irq_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    uart_rx_errflags dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rts_func_en(rts_func_en),
        .baud_div(baud_div), .data_len(data_len), .parity_mode(parity_mode),
        .two_stop(two_stop), .rxd(rxd), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_full(rx_full), .rx_irq(rx_irq),
        .ovr_err(ovr_err), .frm_err(frm_err), .par_err(par_err),
        .err_sum(err_sum), .rts_n(rts_n)
    );

    // Purpose: count receive requests, sampled away from the active edge.
    always @(negedge clk) if (rst_n && rx_irq) irq_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rxd = v;
        repeat (16 * (int'(baud_div) + 1)) @(negedge clk);
    endtask

    // Purpose: send one frame under the current format; flags corrupt it.
    task automatic send(input logic [8:0] d, input bit bad_par,
                        input bit bad_stop1, input bit bad_stop2);
        int nb;
        logic p;
        nb = (data_len == 2'd0) ? 7 : (data_len == 2'd1) ? 8 : 9;
        p = 1'b0;
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            hold_bit(d[i]);
            p = p ^ d[i];
        end
        if (parity_mode == 2'b01 || parity_mode == 2'b10) begin
            if (parity_mode == 2'b01) p = ~p;
            hold_bit(p ^ bad_par);
        end
        hold_bit(!bad_stop1);
        if (two_stop) hold_bit(!bad_stop2);
        hold_bit(1'b1);
        hold_bit(1'b1);
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R2 reset full", rx_full, 0);
        chk("R6 reset err_sum", err_sum, 0);
        chk("R10 rts disabled rx", rts_n, 1);
        rx_en = 1'b1;
        @(negedge clk);
        chk("R10 rts low when empty", rts_n, 0);
    endtask

    task automatic t_basic_8n1();
        int c0;
        c0 = irq_cnt;
        data_len = 2'd1; parity_mode = 2'b00; two_stop = 1'b0;
        send(9'h0A5, 0, 0, 0);
        chk("R8 data 8 bit", rx_data, 9'h0A5);
        chk("R2 full set", rx_full, 1);
        chk("R2 one irq", irq_cnt - c0, 1);
        chk("R6 no errors", err_sum, 0);
        chk("R10 rts high when full", rts_n, 1);
        do_read();
        chk("R11 read clears full", rx_full, 0);
        chk("R10 rts low after read", rts_n, 0);
    endtask

    task automatic t_seven_even();
        data_len = 2'd0; parity_mode = 2'b10; two_stop = 1'b0;
        send(9'h035, 0, 0, 0);
        chk("R8 data 7 bit", rx_data, 9'h035);
        chk("R5 even parity ok", par_err, 0);
        do_read();
    endtask

    task automatic t_parity_err();
        data_len = 2'd1; parity_mode = 2'b01; two_stop = 1'b0;
        send(9'h0C3, 1, 0, 0);
        chk("R5 odd parity error", par_err, 1);
        chk("R6 sum on parity", err_sum, 1);
        chk("R5 data kept", rx_data, 9'h0C3);
        do_read();
        chk("R11 read clears par", par_err, 0);
        send(9'h0C3, 0, 0, 0);
        chk("R5 odd parity ok", par_err, 0);
        do_read();
    endtask

    task automatic t_framing();
        data_len = 2'd1; parity_mode = 2'b00; two_stop = 1'b1;
        send(9'h05A, 0, 0, 1);
        chk("R4 second stop low", frm_err, 1);
        chk("R6 sum on framing", err_sum, 1);
        do_read();
        two_stop = 1'b0;
        send(9'h05A, 0, 1, 0);
        chk("R4 single stop low", frm_err, 1);
        do_read();
        two_stop = 1'b1;
        send(9'h05A, 0, 0, 0);
        chk("R4 two stops good", frm_err, 0);
        do_read();
    endtask

    task automatic t_overrun();
        int c0;
        c0 = irq_cnt;
        data_len = 2'd1; parity_mode = 2'b00; two_stop = 1'b0;
        send(9'h011, 0, 0, 0);
        send(9'h022, 0, 0, 0);
        chk("R3 overwritten", rx_data, 9'h022);
        chk("R3 overrun flag", ovr_err, 1);
        chk("R3 no second irq", irq_cnt - c0, 1);
        chk("R6 sum on overrun", err_sum, 1);
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk);
        chk("R11 disable clears flags", err_sum, 0);
        rx_en = 1'b1;
        do_read();
    endtask

    task automatic t_glitch();
        int c0;
        c0 = irq_cnt;
        @(negedge clk) rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (400) @(negedge clk);
        chk("R7 glitch ignored full", rx_full, 0);
        chk("R7 glitch no irq", irq_cnt - c0, 0);
    endtask

    task automatic t_disabled();
        int c0;
        c0 = irq_cnt;
        rx_en = 1'b0;
        send(9'h0FF, 0, 0, 0);
        chk("R1 disabled nothing", rx_full, 0);
        chk("R1 disabled no irq", irq_cnt - c0, 0);
        rx_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_nine_slow();
        baud_div = 8'd3; data_len = 2'd2; parity_mode = 2'b10; two_stop = 1'b0;
        send(9'h1C3, 0, 0, 0);
        chk("R9 slow rate data", rx_data, 9'h1C3);
        chk("R8 nine bit parity ok", par_err, 0);
        do_read();
        baud_div = 8'd1;
    endtask

    task automatic t_rts_off();
        rts_func_en = 1'b0;
        @(negedge clk);
        chk("R10 rts off stays high", rts_n, 1);
        rts_func_en = 1'b1;
        @(negedge clk);
    endtask

    // Purpose: end a hung run as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R9 watchdog act=timeout exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_8n1();
        t_seven_even();
        t_parity_err();
        t_framing();
        t_overrun();
        t_glitch();
        t_disabled();
        t_nine_slow();
        t_rts_off();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule